// File: doc/BRIEF.md
# Master-to-Context Binding Table

This block holds one small register entry for each bus-master port that sits in front of an address-translation unit. Each entry records whether translation is on for that master, which translation context serves it, an optional fixed upper-address extension, and two 8-bit address-space identifier fields. Software programs the entries over a plain 32-bit register bus. The master-side logic presents a master index on a lookup port and gets back, in the same cycle, the binding for that master.

The register space is split into two non-contiguous windows. The first 32 entries sit in a lower window and the remaining entries in an upper window. Selector code 8 is reserved: it routes the master to a fixed-mapping path instead of a page-table context. Writing the flush bit of an entry raises a one-cycle flush strobe for that entry. The flush bit is not stored. The translation engine and the contexts themselves are outside this block.

Top module: `utlb_bind_table`

## Requirements
- R1: After reset every entry is cleared: all lookups return zeros, all flush strobes are low and the read data is 0.
- R2: The control register of entry n is at byte address 0x300 + 16·n for n < 32, and at 0x600 + 16·(n−32) for 32 ≤ n < 48. A write there changes entry n only.
- R3: Control register fields are: bit 0 translation enable, bits 7:4 context selector, bits 23:16 fixed-address value, bit 31 fixed-address enable. A read returns those fields and 0 in every other bit.
- R4: The identifier register of entry n is 8 bytes above its control register. Bits 15:8 hold the high identifier and bits 7:0 the low identifier. A read returns 0 in bits 31:16.
- R5: A control write with bit 1 set makes flush_o[n] high for exactly the cycle after the write edge, with no other strobe bit set. Bit 1 always reads back as 0.
- R6: For an enabled entry, the lookup port returns lk_en=1, lk_ctx = the selector, and the entry's fixed-address and identifier fields, combinationally from lk_idx.
- R7: lk_fixed is 1 exactly when the looked-up entry is enabled and its selector equals 8.
- R8: A lookup of a disabled entry, or of an index of 48 or above, returns 0 on every lookup output.
- R9: A read at any address outside both windows, at offsets 4 or 12 inside an entry, or at an address that is not 4-byte aligned, returns 0. A write there changes no entry.
- R10: Writing 0x00000000 to an entry's control register disables translation for that master and leaves its identifier register unchanged.
- R11: bus_rdata is registered. It takes the addressed value on the clock edge where bus_rd is high and holds its value when bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lk_idx | input | 6 | Master index to look up |
| lk_en | output | 1 | Translation enabled for that master |
| lk_ctx | output | 4 | Context selector of that master |
| lk_fixed | output | 1 | Master routed to the fixed-mapping path |
| lk_fix_en | output | 1 | Fixed-address extension enabled |
| lk_fix_val | output | 8 | Fixed-address extension value |
| lk_id_hi | output | 8 | High identifier field |
| lk_id_lo | output | 8 | Low identifier field |
| flush_o | output | 48 | One-cycle flush strobe per entry |

## Verification
Every one of the 48 entries is written with its own pattern, computed from its index, that varies the enable, all 16 selector codes including the reserved 8, the fixed-address fields and the flush bit. The write data also sets every reserved bit to 1. Reading all entries back shows whether the two windows decode, whether reserved bits are masked, and whether the entries are distinct. A lookup sweep over all 64 index values separates enabled, disabled and out-of-range masters. Probes just past each window edge, at the unused offsets inside an entry and at unaligned addresses show whether the window split leaks. The bench then checks that the neighbouring entries 0, 32 and 47 are still intact.

// File: rtl/utlb_bind_pkg.sv
package utlb_bind_pkg;

  localparam int SEL_W = 4;
  localparam int BYTE_W = 8;
  localparam logic [SEL_W-1:0] SEL_FIXED = 4'd8;

  typedef struct packed {
    logic              en;
    logic [SEL_W-1:0]  sel;
    logic              fix_en;
    logic [BYTE_W-1:0] fix_val;
    logic [BYTE_W-1:0] id_hi;
    logic [BYTE_W-1:0] id_lo;
  } bind_entry_t;

  function automatic logic [31:0] pack_ctrl(bind_entry_t e);
    return {e.fix_en, 7'b0, e.fix_val, 8'b0, e.sel, 3'b0, e.en};
  endfunction

  function automatic logic [31:0] pack_id(bind_entry_t e);
    return {16'b0, e.id_hi, e.id_lo};
  endfunction

  function automatic bind_entry_t unpack_wdata(logic [31:0] w);
    bind_entry_t e;
    e.en      = w[0];
    e.sel     = w[7:4];
    e.fix_en  = w[31];
    e.fix_val = w[23:16];
    e.id_hi   = w[15:8];
    e.id_lo   = w[7:0];
    return e;
  endfunction

endpackage

// File: rtl/utlb_addr_decode.sv
module utlb_addr_decode #(
  parameter int ADDR_W = 12,
  parameter int NUM_ENTRIES = 48,
  parameter int SPLIT_IDX = 32,
  parameter int STRIDE_LG2 = 4,
  parameter int ID_OFS = 8,
  parameter logic [ADDR_W-1:0] BASE_LO = 12'h300,
  parameter logic [ADDR_W-1:0] BASE_HI = 12'h600,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_hit,
  output logic              id_hit,
  output logic [IDX_W-1:0]  idx
);

  localparam int LO_SPAN = SPLIT_IDX << STRIDE_LG2;
  localparam int HI_SPAN = (NUM_ENTRIES - SPLIT_IDX) << STRIDE_LG2;
  localparam logic [ADDR_W-1:0] LO_END = ADDR_W'(int'(BASE_LO) + LO_SPAN);
  localparam logic [ADDR_W-1:0] HI_END = ADDR_W'(int'(BASE_HI) + HI_SPAN);
  localparam logic [STRIDE_LG2-1:0] OFS_CTRL = '0;
  localparam logic [STRIDE_LG2-1:0] OFS_ID = STRIDE_LG2'(ID_OFS);

  logic              in_lo, in_hi, in_any;
  logic [ADDR_W-1:0] rel, idx_wide;
  logic [STRIDE_LG2-1:0] off;

  always_comb begin
    in_lo    = (addr >= BASE_LO) && (addr < LO_END);
    in_hi    = (addr >= BASE_HI) && (addr < HI_END);
    rel      = in_lo ? (addr - BASE_LO) : (addr - BASE_HI);
    off      = rel[STRIDE_LG2-1:0];
    idx_wide = (rel >> STRIDE_LG2) + (in_hi ? ADDR_W'(SPLIT_IDX) : '0);
    in_any   = (in_lo || in_hi) && (idx_wide[ADDR_W-1:IDX_W] == '0);
    ctrl_hit = in_any && (off == OFS_CTRL);
    id_hit   = in_any && (off == OFS_ID);
    idx      = idx_wide[IDX_W-1:0];
  end

endmodule

// File: rtl/utlb_bind_entry.sv
module utlb_bind_entry
  import utlb_bind_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_id,
  input  bind_entry_t wr_val,
  input  logic        flush_req,
  output bind_entry_t ent_o,
  output logic        flush_o
);

  bind_entry_t ent_q, ent_d;
  logic        ent_ld;
  logic        flush_q, flush_d;

  always_comb begin
    ent_d  = ent_q;
    ent_ld = wr_ctrl || wr_id;
    if (wr_ctrl) begin
      ent_d.en      = wr_val.en;
      ent_d.sel     = wr_val.sel;
      ent_d.fix_en  = wr_val.fix_en;
      ent_d.fix_val = wr_val.fix_val;
    end
    if (wr_id) begin
      ent_d.id_hi = wr_val.id_hi;
      ent_d.id_lo = wr_val.id_lo;
    end
    flush_d = wr_ctrl && flush_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (ent_ld) begin
      ent_q <= ent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_d;
    end
  end

  assign ent_o   = ent_q;
  assign flush_o = flush_q;

endmodule

// File: rtl/utlb_bind_lookup.sv
module utlb_bind_lookup
  import utlb_bind_pkg::*;
#(
  parameter int NUM_ENTRIES = 48,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  bind_entry_t      ents [NUM_ENTRIES],
  input  logic [IDX_W-1:0] idx,
  output bind_entry_t      hit_o,
  output logic             fixed_o
);

  logic             in_range;
  logic [IDX_W-1:0] safe_idx;
  bind_entry_t      sel_ent;

  always_comb begin
    in_range = 32'(idx) < NUM_ENTRIES;
    safe_idx = in_range ? idx : '0;
    sel_ent  = ents[safe_idx];
    hit_o    = '0;
    if (in_range && sel_ent.en) begin
      hit_o = sel_ent;
    end
    fixed_o = hit_o.en && (hit_o.sel == SEL_FIXED);
  end

endmodule

// File: rtl/utlb_bind_table.sv
module utlb_bind_table
  import utlb_bind_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_ENTRIES = 48,
  parameter int SPLIT_IDX = 32,
  parameter int STRIDE_LG2 = 4,
  parameter int ID_OFS = 8,
  parameter logic [ADDR_W-1:0] BASE_LO = 12'h300,
  parameter logic [ADDR_W-1:0] BASE_HI = 12'h600,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [IDX_W-1:0]       lk_idx,
  output logic                   lk_en,
  output logic [SEL_W-1:0]       lk_ctx,
  output logic                   lk_fixed,
  output logic                   lk_fix_en,
  output logic [BYTE_W-1:0]      lk_fix_val,
  output logic [BYTE_W-1:0]      lk_id_hi,
  output logic [BYTE_W-1:0]      lk_id_lo,
  output logic [NUM_ENTRIES-1:0] flush_o
);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             dec_ctrl_hit, dec_id_hit;
  logic [IDX_W-1:0] dec_idx;
  bind_entry_t      wr_val;
  logic             wr_flush;
  logic             wdata_unused;

  utlb_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES), .SPLIT_IDX(SPLIT_IDX),
    .STRIDE_LG2(STRIDE_LG2), .ID_OFS(ID_OFS),
    .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
  ) u_dec (
    .addr(bus_addr), .ctrl_hit(dec_ctrl_hit), .id_hit(dec_id_hit), .idx(dec_idx)
  );

  assign wr_val       = unpack_wdata(bus_wdata);
  assign wr_flush     = bus_wdata[1];
  assign wdata_unused = ^{bus_wdata[30:24], bus_wdata[3:2]};

  bind_entry_t ents [NUM_ENTRIES];

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
    logic sel_n;
    assign sel_n = (dec_idx == IDX_W'(n));
    utlb_bind_entry u_ent (
      .clk(clk), .rst_n(rst_sync_n),
      .wr_ctrl(bus_wr && dec_ctrl_hit && sel_n),
      .wr_id(bus_wr && dec_id_hit && sel_n),
      .wr_val(wr_val), .flush_req(wr_flush),
      .ent_o(ents[n]), .flush_o(flush_o[n])
    );
  end

  // registered read port
  logic [31:0] rdata_q, rdata_d, rd_word;

  always_comb begin
    rd_word = '0;
    if (dec_ctrl_hit) begin
      rd_word = pack_ctrl(ents[dec_idx]);
    end else if (dec_id_hit) begin
      rd_word = pack_id(ents[dec_idx]);
    end
    rdata_d = bus_rd ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  bind_entry_t lk_hit;

  utlb_bind_lookup #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk (
    .ents(ents), .idx(lk_idx), .hit_o(lk_hit), .fixed_o(lk_fixed)
  );

  assign lk_en      = lk_hit.en;
  assign lk_ctx     = lk_hit.sel;
  assign lk_fix_en  = lk_hit.fix_en;
  assign lk_fix_val = lk_hit.fix_val;
  assign lk_id_hi   = lk_hit.id_hi;
  assign lk_id_lo   = lk_hit.id_lo;

endmodule

// File: rtl/utlb_bind_chk.sv
module utlb_bind_chk #(
  parameter int NUM_ENTRIES = 48,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic                   wr_flush,
  input logic                   dec_ctrl_hit,
  input logic                   dec_id_hit,
  input logic [31:0]            bus_rdata,
  input logic [IDX_W-1:0]       lk_idx,
  input logic                   lk_en,
  input logic [3:0]             lk_ctx,
  input logic                   lk_fixed,
  input logic [NUM_ENTRIES-1:0] flush_o
);

  // R5
  flush_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(flush_o));

  // R5
  flush_follows_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && dec_ctrl_hit && wr_flush) |=> ($countones(flush_o) == 1));

  // R5
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flush_o != '0) |-> $past(bus_wr && dec_ctrl_hit && wr_flush));

  // R8
  lk_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (32'(lk_idx) >= NUM_ENTRIES) |-> (!lk_en && lk_ctx == 4'd0));

  // R7
  lk_fixed_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_fixed |-> (lk_en && lk_ctx == 4'd8));

  // R9
  rd_miss_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && !dec_ctrl_hit && !dec_id_hit) |=> (bus_rdata == 32'd0));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind utlb_bind_table utlb_bind_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .wr_flush(wr_flush), .dec_ctrl_hit(dec_ctrl_hit), .dec_id_hit(dec_id_hit),
  .bus_rdata(bus_rdata), .lk_idx(lk_idx), .lk_en(lk_en), .lk_ctx(lk_ctx),
  .lk_fixed(lk_fixed), .flush_o(flush_o)
);

// File: tb/utlb_bind_table_bench.sv
`timescale 1ns/1ps
module utlb_bind_table_bench;

  localparam int N = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [5:0]  lk_idx;
  logic        lk_en, lk_fixed, lk_fix_en;
  logic [3:0]  lk_ctx;
  logic [7:0]  lk_fix_val, lk_id_hi, lk_id_lo;
  logic [N-1:0] flush_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  utlb_bind_table u_utlb_bind_table (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_idx(lk_idx), .lk_en(lk_en), .lk_ctx(lk_ctx), .lk_fixed(lk_fixed),
    .lk_fix_en(lk_fix_en), .lk_fix_val(lk_fix_val), .lk_id_hi(lk_id_hi),
    .lk_id_lo(lk_id_lo), .flush_o(flush_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ctrl_addr(int n);
    return (n < 32) ? 12'(12'h300 + 16 * n) : 12'(12'h600 + 16 * (n - 32));
  endfunction

  function automatic bit p_en(int n);  return (n % 3) != 0; endfunction
  function automatic logic [3:0] p_sel(int n); return 4'(n % 16); endfunction
  function automatic bit p_fixen(int n); return n[0]; endfunction
  function automatic logic [7:0] p_fixv(int n); return 8'(n * 5 + 1); endfunction
  function automatic bit p_flush(int n); return (n % 4) == 1; endfunction
  function automatic logic [7:0] p_hi(int n); return 8'(n) ^ 8'hA5; endfunction
  function automatic logic [7:0] p_lo(int n); return 8'(n + 7); endfunction

  function automatic logic [31:0] exp_ctrl(int n);
    return {p_fixen(n), 7'b0, p_fixv(n), 8'b0, p_sel(n), 3'b0, p_en(n)};
  endfunction

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic lookup_chk(int i, string req);
    bit on;
    lk_idx = 6'(i);
    #1;
    on = (i < N) && p_en(i);
    chk({req, " lk_en"}, 64'(lk_en), 64'(on));
    chk({req, " lk_ctx"}, 64'(lk_ctx), on ? 64'(p_sel(i)) : 64'd0);
    chk({req, " R7 lk_fixed"}, 64'(lk_fixed), 64'(on && p_sel(i) == 4'd8));
    chk({req, " fields"}, {40'd0, lk_fix_en, lk_fix_val, lk_id_hi, lk_id_lo},
        on ? {40'd0, p_fixen(i), p_fixv(i), p_hi(i), p_lo(i)} : 64'd0);
  endtask

  initial begin
    logic [31:0] rd;
    logic [11:0] bad [8];
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    bus_wdata = '0; lk_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 flush", 64'(flush_o), 64'd0);
    chk("R1 rdata", 64'(bus_rdata), 64'd0);
    lk_idx = 6'd5; #1;
    chk("R1 lookup", {lk_en, lk_ctx, lk_id_lo}, 64'd0);
    do_read(ctrl_addr(47), rd);
    chk("R1 ctrl47", 64'(rd), 64'd0);

    // R2 R3 R4 R5: program every entry; reserved bits set to 1 in wdata
    for (int n = 0; n < N; n++) begin
      do_write(ctrl_addr(n), {p_fixen(n), 7'h7F, p_fixv(n), 8'hFF, p_sel(n),
                              2'b11, p_flush(n), p_en(n)});
      chk("R5 flush strobe", 64'(flush_o),
          p_flush(n) ? (64'd1 << n) : 64'd0);
      do_write(ctrl_addr(n) + 12'd8, {16'hFFFF, p_hi(n), p_lo(n)});
      chk("R5 flush one cycle", 64'(flush_o), 64'd0);
    end

    for (int n = 0; n < N; n++) begin
      do_read(ctrl_addr(n), rd);
      chk("R2 R3 ctrl readback", 64'(rd), 64'(exp_ctrl(n)));
      do_read(ctrl_addr(n) + 12'd8, rd);
      chk("R4 id readback", 64'(rd), {48'd0, p_hi(n), p_lo(n)});
    end

    // R6 R7 R8 lookup sweep over every index value
    for (int i = 0; i < 64; i++) lookup_chk(i, "R6 R8");

    // R9 holes: past window edges, unused offsets, unaligned
    bad[0] = 12'h2FC; bad[1] = 12'h304; bad[2] = 12'h30C; bad[3] = 12'h500;
    bad[4] = 12'h5F0; bad[5] = 12'h700; bad[6] = 12'h302; bad[7] = 12'h609;
    for (int k = 0; k < 8; k++) begin
      do_read(ctrl_addr(1), rd);
      do_read(bad[k], rd);
      chk("R9 hole read", 64'(rd), 64'd0);
    end
    for (int k = 0; k < 8; k++) begin
      do_write(bad[k], 32'hFFFF_FFFF);
      chk("R9 hole write no flush", 64'(flush_o), 64'd0);
    end
    do_read(ctrl_addr(0), rd);  chk("R9 entry0 intact", 64'(rd), 64'(exp_ctrl(0)));
    do_read(ctrl_addr(32), rd); chk("R9 entry32 intact", 64'(rd), 64'(exp_ctrl(32)));
    do_read(ctrl_addr(47), rd); chk("R9 entry47 intact", 64'(rd), 64'(exp_ctrl(47)));
    do_read(ctrl_addr(0) + 12'd8, rd);
    chk("R9 id0 intact", 64'(rd), {48'd0, p_hi(0), p_lo(0)});

    // R11 hold with bus_rd low
    do_read(ctrl_addr(1), rd);
    bus_addr = 12'h304;
    repeat (2) @(negedge clk);
    chk("R11 rdata hold", 64'(bus_rdata), 64'(exp_ctrl(1)));

    // R10 zero write disables (entry 40: enabled, selector 8)
    lk_idx = 6'd40; #1;
    chk("R7 fixed before disable", 64'(lk_fixed), 64'd1);
    do_write(ctrl_addr(40), 32'h0);
    lk_idx = 6'd40; #1;
    chk("R10 lk_en after zero", {lk_en, lk_ctx, lk_fixed}, 64'd0);
    do_read(ctrl_addr(40), rd);
    chk("R10 ctrl reads zero", 64'(rd), 64'd0);
    do_read(ctrl_addr(40) + 12'd8, rd);
    chk("R10 id kept", 64'(rd), {48'd0, p_hi(40), p_lo(40)});

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule